// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory. It watches a clock line and a data line from the bus, detects START and STOP framing, and answers only when the slave address it hears carries the fixed prefix `1010` followed by the three bits on its strap inputs. A write command loads a two-byte word address into an internal pointer. Any data bytes that follow are stored at successive locations of a synchronous byte-wide RAM, which stands in for the nonvolatile array. A read command returns bytes from the pointer for as long as the master acknowledges them. A random read is a write-address phase, then a repeated START, then a read.

The data line is never driven high. The block only produces an enable that pulls the line low, and an external open-drain pad combines it with the master's drive. Both bus lines pass through a synchronizer clocked by a system clock that runs much faster than the serial clock. A write-protect input stops every change to the array, but the bus still acknowledges the data bytes. The array depth is `2**ADDR_W` bytes; `ADDR_W = 14` gives the full 16K x 8 organization.

Top module: `serial_mem_slave`

## Requirements
- R1: A START (data falling while the synchronized clock is high) begins a new command from any state, including a repeated START in the middle of a command. A STOP (data rising while the clock is high) returns the block to idle with the data line released.
- R2: The first byte after START is the slave address. Bits [7:4] must equal `1010`, bits [3:1] must equal `strap_i[2:1:0]`, and bit 0 selects read (1) or write (0). On a mismatch the address is not acknowledged, and the rest of the command is ignored until the next START.
- R3: The block pulls the data line low throughout the 9th clock after a matching slave address, after each word-address byte and after each write data byte.
- R4: Incoming bits are sampled on the rising clock edge. The slave changes its data-line drive only while the clock is low, and it only pulls the line low or releases it.
- R5: A write command carries the word address high byte first, and the high bits beyond `ADDR_W` are ignored. The data bytes that follow are stored at consecutive addresses starting at that word address.
- R6: A read command with no preceding address phase starts at the internal pointer, which is left one past the last byte transferred.
- R7: A write-address phase followed by a repeated START and a read returns the data stored at the loaded word address.
- R8: During a read, the slave releases the line for the master's acknowledge clock. On an acknowledge it sends the next byte. On a NoACK it stops driving and ignores further clocks until START or STOP.
- R9: The internal pointer advances after every data byte written or read, and it wraps from `2**ADDR_W-1` to 0.
- R10: While `wp_i` is high, write data bytes are acknowledged but the array is left unchanged.
- R11: Before the first START, and after a STOP, clocked bytes on the bus get no acknowledge and cause no drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull-low enable for the open-drain data pad |
| strap_i | input | 3 | Pin-strapped slave address bits |
| wp_i | input | 1 | Write protect, high blocks array writes |

## Verification
The bench builds the block with `ADDR_W = 8` and the default two-stage synchronizer, and straps the address to `101`. The 256-byte array makes the wrap from the last location back to address 0 reachable with a single two-byte write and a single read. With `ADDR_W = 8`, the whole high word-address byte falls beyond `ADDR_W`, so sending a nonzero high byte shows that the extra bits are discarded. A serial half-period of 16 system clocks leaves room for the synchronizer delay, so the bench can show that the slave's drive never changes while the clock is high.

// File: rtl/sms_pkg.sv
package sms_pkg;

   localparam int BYTE_W = 8;
   localparam int WORD_ADDR_W = 2 * BYTE_W;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_AHI,
      ST_AHI_ACK,
      ST_ALO,
      ST_ALO_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } sms_state_e;

endpackage

// File: rtl/sms_line_sense.sv
module sms_line_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [SYNC_STAGES-1:0] scl_ff;
   logic [SYNC_STAGES-1:0] sda_ff;
   logic                   scl_q;
   logic                   sda_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               scl_ff[0] <= 1'b1;
               sda_ff[0] <= 1'b1;
            end else begin
               scl_ff[0] <= scl_i;
               sda_ff[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               scl_ff[i] <= 1'b1;
               sda_ff[i] <= 1'b1;
            end else begin
               scl_ff[i] <= scl_ff[i-1];
               sda_ff[i] <= sda_ff[i-1];
            end
         end
      end
   end

   assign scl_s = scl_ff[SYNC_STAGES-1];
   assign sda_s = sda_ff[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/sms_ram.sv
module sms_ram #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
      rdata <= cells[raddr];
   end

endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
   import sms_pkg::*;
#(
   parameter int          ADDR_W     = 11,
   parameter logic [3:0]  DEV_PREFIX = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [2:0]        strap,
   input  logic              wp,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic              sda_pull,
   output sms_state_e        state_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              inc_o
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
   localparam logic [3:0]        BITS_FULL = 4'd8;

   sms_state_e        state;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] rx_sr;
   logic [BYTE_W-1:0] tx_sr;
   logic [BYTE_W-1:0] ahi_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rw_q;
   logic              mack_q;
   logic              pull_q;

   logic                   rx_state;
   logic                   byte_in;
   logic                   dev_hit;
   logic                   load_now;
   logic                   wr_now;
   logic                   rd_load;
   logic                   inc_now;
   logic [WORD_ADDR_W-1:0] word_addr;

   assign rx_state = (state == ST_DEV) || (state == ST_AHI) ||
                     (state == ST_ALO) || (state == ST_WR);
   assign byte_in  = rx_state && scl_fall && (bit_cnt == BITS_FULL);
   assign dev_hit  = (rx_sr[7:4] == DEV_PREFIX) && (rx_sr[3:1] == strap);
   assign load_now = byte_in && (state == ST_ALO);
   assign wr_now   = byte_in && (state == ST_WR);
   assign rd_load  = scl_fall && !start_det && !stop_det &&
                     (((state == ST_DEV_ACK) && rw_q) ||
                      ((state == ST_RD_ACK) && mack_q));
   assign inc_now  = (wr_now || rd_load) && !start_det && !stop_det;
   assign word_addr = {ahi_q, rx_sr};

   // word pointer: loaded by the address phase, bumped per data byte
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load_now && !start_det && !stop_det) begin
         addr_q <= word_addr[ADDR_W-1:0];
      end else if (inc_now) begin
         addr_q <= addr_q + ADDR_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         rx_sr   <= '0;
         tx_sr   <= '0;
         ahi_q   <= '0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
         pull_q  <= 1'b0;
      end else if (start_det) begin
         state   <= ST_DEV;
         bit_cnt <= '0;
         pull_q  <= 1'b0;
      end else if (stop_det) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         pull_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               pull_q <= 1'b0;
            end
            ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
               if (scl_rise && bit_cnt != BITS_FULL) begin
                  rx_sr   <= {rx_sr[BYTE_W-2:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_in) begin
                  unique case (state)
                     ST_DEV: begin
                        rw_q <= rx_sr[0];
                        if (dev_hit) begin
                           pull_q <= 1'b1;
                           state  <= ST_DEV_ACK;
                        end else begin
                           state  <= ST_IDLE;
                        end
                     end
                     ST_AHI: begin
                        ahi_q  <= rx_sr;
                        pull_q <= 1'b1;
                        state  <= ST_AHI_ACK;
                     end
                     ST_ALO: begin
                        pull_q <= 1'b1;
                        state  <= ST_ALO_ACK;
                     end
                     default: begin
                        pull_q <= 1'b1;
                        state  <= ST_WR_ACK;
                     end
                  endcase
               end
            end
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (rd_load) begin
                     tx_sr  <= {mem_rdata[BYTE_W-2:0], 1'b0};
                     pull_q <= ~mem_rdata[BYTE_W-1];
                     state  <= ST_RD;
                  end else begin
                     pull_q <= 1'b0;
                     unique case (state)
                        ST_DEV_ACK: state <= ST_AHI;
                        ST_AHI_ACK: state <= ST_ALO;
                        default:    state <= ST_WR;
                     endcase
                  end
               end
            end
            ST_RD: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (scl_fall) begin
                  if (bit_cnt == BITS_FULL) begin
                     pull_q <= 1'b0;
                     mack_q <= 1'b0;
                     state  <= ST_RD_ACK;
                  end else begin
                     pull_q <= ~tx_sr[BYTE_W-1];
                     tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) begin
                  mack_q <= ~sda_s;
               end else if (scl_fall) begin
                  bit_cnt <= '0;
                  if (rd_load) begin
                     tx_sr  <= {mem_rdata[BYTE_W-2:0], 1'b0};
                     pull_q <= ~mem_rdata[BYTE_W-1];
                     state  <= ST_RD;
                  end else begin
                     pull_q <= 1'b0;
                     state  <= ST_IDLE;
                  end
               end
            end
            default: begin
               state  <= ST_IDLE;
               pull_q <= 1'b0;
            end
         endcase
      end
   end

   assign mem_we    = wr_now && !wp && !start_det && !stop_det;
   assign mem_waddr = addr_q;
   assign mem_wdata = rx_sr;
   assign mem_raddr = addr_q;
   assign sda_pull  = pull_q;
   assign state_o   = state;
   assign addr_o    = addr_q;
   assign inc_o     = inc_now;

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
   import sms_pkg::*;
#(
   parameter int         ADDR_W      = 11,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);

   if (ADDR_W < 1 || ADDR_W > WORD_ADDR_W) begin : g_bad_addr_w
      $error("serial_mem_slave: ADDR_W must lie in 1..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("serial_mem_slave: SYNC_STAGES must be at least 2");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [BYTE_W-1:0] mem_wdata;
   logic [ADDR_W-1:0] mem_raddr;
   logic [BYTE_W-1:0] mem_rdata;
   sms_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic              addr_inc;

   sms_line_sense #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   sms_ctrl #(
      .ADDR_W     (ADDR_W),
      .DEV_PREFIX (DEV_PREFIX)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .strap     (strap_i),
      .wp        (wp_i),
      .mem_rdata (mem_rdata),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .mem_wdata (mem_wdata),
      .mem_raddr (mem_raddr),
      .sda_pull  (sda_oe_o),
      .state_o   (state),
      .addr_o    (addr_q),
      .inc_o     (addr_inc)
   );

   sms_ram #(
      .ADDR_W (ADDR_W),
      .DATA_W (BYTE_W)
   ) u_ram (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

endmodule

// File: rtl/sms_checker.sv
module sms_checker
   import sms_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start_det,
   input logic              stop_det,
   input logic              sda_oe_o,
   input sms_state_e        state,
   input logic [ADDR_W-1:0] addr_q,
   input logic              addr_inc
);

   localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

   assert_start_enters_address_R1: assert property (
      @(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_DEV));

   assert_stop_releases_R1: assert property (
      @(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe_o && state == ST_IDLE));

   assert_drive_moves_on_low_clock_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

   assert_master_ack_slot_free_R8: assert property (
      @(posedge clk) disable iff (!rst_n)
      (state == ST_RD_ACK) |-> !sda_oe_o);

   assert_pointer_wraps_R9: assert property (
      @(posedge clk) disable iff (!rst_n)
      (addr_inc && addr_q == ADDR_MAX) |=> (addr_q == '0));

   assert_idle_is_quiet_R11: assert property (
      @(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe_o);

endmodule

bind serial_mem_slave sms_checker #(
   .ADDR_W (ADDR_W)
) u_sms_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe_o  (sda_oe_o),
   .state     (state),
   .addr_q    (addr_q),
   .addr_inc  (addr_inc)
);

// File: tb/serial_mem_slave_test.sv
`timescale 1ns/1ps
module serial_mem_slave_test;

   localparam int H = 16;
   localparam logic [7:0] DEV_W = 8'hAA;   // 1010 101 0
   localparam logic [7:0] DEV_R = 8'hAB;   // 1010 101 1

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic wp = 1'b0;
   logic [2:0] strap = 3'b101;
   logic sda_oe;
   logic sda_bus;

   int checks = 0;
   int errors = 0;
   int r4_viol = 0;
   logic prev_oe = 1'b0;

   assign sda_bus = ~(m_low | sda_oe);

   always #2.5 clk = ~clk;

   serial_mem_slave #(
      .ADDR_W      (8),
      .SYNC_STAGES (2)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_bus),
      .sda_oe_o (sda_oe),
      .strap_i  (strap),
      .wp_i     (wp)
   );

   // R4: slave drive must not move while the raw clock is high
   always @(negedge clk) begin
      if (rst_n && scl && (sda_oe !== prev_oe)) r4_viol++;
      prev_oe <= sda_oe;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic hw();
      repeat (H) @(negedge clk);
   endtask

   task automatic gap();
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; hw();
      scl = 1'b1;   hw();
      m_low = 1'b1; hw();
      scl = 1'b0;   gap();
   endtask

   task automatic bus_stop();
      m_low = 1'b1; hw();
      scl = 1'b1;   hw();
      m_low = 1'b0; hw();
   endtask

   task automatic tx_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         m_low = ~b[i]; hw();
         scl = 1'b1;    hw();
         scl = 1'b0;    gap();
      end
      m_low = 1'b0; hw();
      scl = 1'b1;   hw();
      acked = (sda_bus == 1'b0);
      scl = 1'b0;   gap();
   endtask

   task automatic rx_byte(input bit give_ack, output logic [7:0] b);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         hw();
         scl = 1'b1; hw();
         b[i] = sda_bus;
         scl = 1'b0; gap();
      end
      m_low = give_ack; hw();
      scl = 1'b1;       hw();
      scl = 1'b0;       gap();
      m_low = 1'b0;
   endtask

   task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo,
                             input string req);
      bit a;
      bus_start();
      tx_byte(DEV_W, a); check(a, "R3", {req, " device ack"}, a, 1);
      tx_byte(hi, a);    check(a, "R3", {req, " high addr ack"}, a, 1);
      tx_byte(lo, a);    check(a, "R3", {req, " low addr ack"}, a, 1);
   endtask

   task automatic test_reset();
      check(sda_oe == 1'b0, "R1", "released after reset", sda_oe, 0);
   endtask

   task automatic test_ignore_before_start();
      bit a;
      tx_byte(DEV_W, a);
      check(!a, "R11", "no ack without START", a, 0);
   endtask

   task automatic test_write_random_read();
      bit a;
      logic [7:0] d;
      logic [7:0] pat [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
      addr_phase(8'hC0, 8'h10, "R5");
      for (int i = 0; i < 4; i++) begin
         tx_byte(pat[i], a);
         check(a, "R3", "write data ack", a, 1);
      end
      bus_stop();
      addr_phase(8'h00, 8'h10, "R7");
      bus_start();
      tx_byte(DEV_R, a); check(a, "R2", "read address ack", a, 1);
      for (int i = 0; i < 3; i++) begin
         rx_byte(i < 2, d);
         check(d == pat[i], "R7", "random/sequential read", d, pat[i]);
      end
      bus_stop();
      // pointer now one past the last byte read (0x13)
      bus_start();
      tx_byte(DEV_R, a);
      rx_byte(1'b0, d);
      check(d == 8'hD4, "R6", "current-address read", d, 8'hD4);
      bus_stop();
   endtask

   task automatic test_mismatch();
      bit a;
      bus_start();
      tx_byte(8'hA8, a);  // strap bits 100
      check(!a, "R2", "strap mismatch not acked", a, 0);
      tx_byte(8'h00, a);
      check(!a, "R2", "rest ignored after mismatch", a, 0);
      bus_stop();
      bus_start();
      tx_byte(8'hBA, a);  // prefix 1011
      check(!a, "R2", "prefix mismatch not acked", a, 0);
      bus_stop();
   endtask

   task automatic test_write_protect();
      bit a;
      logic [7:0] d;
      wp = 1'b1;
      addr_phase(8'h00, 8'h10, "R10");
      tx_byte(8'h55, a);
      check(a, "R10", "protected data still acked", a, 1);
      bus_stop();
      wp = 1'b0;
      addr_phase(8'h00, 8'h10, "R10");
      bus_start();
      tx_byte(DEV_R, a);
      rx_byte(1'b0, d);
      check(d == 8'hA1, "R10", "array unchanged under protect", d, 8'hA1);
      bus_stop();
   endtask

   task automatic test_wrap();
      bit a;
      logic [7:0] d;
      addr_phase(8'h00, 8'hFF, "R9");
      tx_byte(8'h77, a);
      tx_byte(8'h88, a);
      bus_stop();
      addr_phase(8'h00, 8'hFF, "R9");
      bus_start();
      tx_byte(DEV_R, a);
      rx_byte(1'b1, d);
      check(d == 8'h77, "R9", "last location", d, 8'h77);
      rx_byte(1'b0, d);
      check(d == 8'h88, "R9", "wrapped to location 0", d, 8'h88);
      bus_stop();
   endtask

   task automatic test_noack();
      bit a;
      logic [7:0] d;
      int low_seen = 0;
      addr_phase(8'h00, 8'h10, "R8");
      bus_start();
      tx_byte(DEV_R, a);
      rx_byte(1'b0, d);
      check(sda_oe == 1'b0, "R8", "released after NoACK", sda_oe, 0);
      for (int i = 0; i < 9; i++) begin
         hw();
         scl = 1'b1; hw();
         if (sda_bus == 1'b0) low_seen++;
         scl = 1'b0; gap();
      end
      check(low_seen == 0, "R8", "silent after NoACK", low_seen, 0);
      bus_stop();
   endtask

   task automatic test_stop_midway();
      bit a;
      addr_phase(8'h00, 8'h20, "R1");
      bus_stop();
      check(sda_oe == 1'b0, "R1", "STOP releases line", sda_oe, 0);
      tx_byte(8'h3C, a);
      check(!a, "R11", "byte after STOP not acked", a, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      test_reset();
      test_ignore_before_start();
      test_write_random_read();
      test_mismatch();
      test_write_protect();
      test_wrap();
      test_noack();
      test_stop_midway();
      check(r4_viol == 0, "R4", "drive changes while clock high", r4_viol, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule